// File: doc/BRIEF.md
# System-Control Port Bank

This block is a byte-wide register bank for an I/O space. It decodes a fixed set of port addresses used for platform system control. Writes reach a handful of stored control bits: a soft-reset request line, a byte-order flag, a disk-activity lamp bit, a small system-control field and an I/O-map-type flag. Writes to two other ports fire single-cycle lock-toggle strobes toward an external non-volatile memory. A set of read-only ports returns fixed identification and feature bytes. One port behaves differently for reads and writes: a write drives both reset and byte order, while a read returns only the byte-order bit.

The bus is synchronous and has no handshake. An address and a write strobe with data complete in one clock. An address and a read strobe return data on `rd_data_o` in the next cycle, and that value holds until the next read that is accepted. A small access tracker records how the previous cycle's access ended. Its states are ACC_IDLE (no access), ACC_READ (read accepted), ACC_WRITE (write accepted) and ACC_FAULT (rejected access). It moves each cycle:
- to ACC_FAULT when both strobes are high, when a write hits a port that takes no writes, or when a read hits a port that takes no reads;
- to ACC_WRITE on a lone write to a port that takes writes;
- to ACC_READ on a lone read to a port that takes reads;
- to ACC_IDLE when neither strobe is high.

`err_o` is high exactly while the tracker is in ACC_FAULT. Reads of ports that take no reads return 0xFF.

Top module: `sysctl_port_bank`

## Requirements
- R1: A write to port 0x0092 sets `soft_rst_o` to data bit 0 from the next cycle on, and it holds until the next write to that port or a reset.
- R2: A write to port 0x0092 sets `endian_o` to data bit 1. A read of 0x0092 returns the flag in bit 1 with all other bits zero.
- R3: A write to port 0x0808 sets `activity_o` to data bit 0.
- R4: Each write to 0x0810 raises `lock1_o`, and each write to 0x0812 raises `lock2_o`, for exactly the one cycle after the write, whatever the data. The two strobes are never high together.
- R5: A write to 0x081C stores the low CTRL_W data bits on `ctrl_o`. A read of 0x081C returns them zero-extended.
- R6: A write to 0x0850 drives data bit 0 on `map_o` from the next cycle. A read of 0x0850 returns the flag in bit 0 with other bits zero.
- R7: Reads return fixed bytes: 0x0800 gives 0xEF, 0x0802 gives 0xAD, 0x0803 gives 0xE0, 0x080C gives 0x3C, 0x0810 gives 0x39, 0x0818 gives 0x00 and 0x0823 gives 0x03. Read data appears the cycle after the strobe and holds until the next accepted read.
- R8: Writes to the read-only ports 0x0800, 0x0802 and 0x0803, and to the cache-invalidate port 0x0814, are accepted without error and change no output.
- R9: The ports that take reads are 0x0092, 0x0800, 0x0802, 0x0803, 0x080C, 0x0810, 0x0814, 0x0818, 0x081C, 0x0823 and 0x0850. A read of 0x0814 returns 0xFF with no error. A read of any other address returns 0xFF and raises `err_o`.
- R10: The ports that take writes are 0x0092, 0x0800, 0x0802, 0x0803, 0x0808, 0x0810, 0x0812, 0x0814, 0x081C and 0x0850. Any other write, and any cycle with both strobes high, raises `err_o` for one cycle and changes no stored state, no strobe and no read data.
- R11: A synchronous reset clears `soft_rst_o`, `endian_o`, `activity_o`, `ctrl_o`, `map_o`, `err_o`, both lock strobes and `rd_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Port address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Read data, valid the cycle after a read |
| err_o | output | 1 | One-cycle pulse after a rejected access |
| soft_rst_o | output | 1 | Soft-reset request level |
| endian_o | output | 1 | Byte-order mode flag |
| activity_o | output | 1 | Disk-activity lamp bit |
| lock1_o | output | 1 | Lock-toggle strobe 1 |
| lock2_o | output | 1 | Lock-toggle strobe 2 |
| ctrl_o | output | CTRL_W | Stored system-control field |
| map_o | output | 1 | I/O-map-type flag |

## Verification
The bench builds the bank with ADDR_W = 12 and CTRL_W = 4. The narrow address makes all 4096 addresses cheap enough to sweep. Every address is read with the state cleared and again with non-zero state, and every address is written with zero. Every address that takes no writes is also written with all ones. This shows the decode is exact and that no rejected access disturbs anything. With a 4-bit field, all 256 data bytes can be written to the control port to show the masking.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_RSTEND,
        SEL_CPUID,
        SEL_FEAT,
        SEL_MODSTAT,
        SEL_LAMP,
        SEL_EQUIP,
        SEL_LOCK1,
        SEL_LOCK2,
        SEL_INVAL,
        SEL_KEY,
        SEL_CTRL,
        SEL_CACHE,
        SEL_MAP
    } sel_e;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_READ,
        ACC_WRITE,
        ACC_FAULT
    } acc_e;

    localparam logic [31:0] PORT_RSTEND  = 32'h0092;
    localparam logic [31:0] PORT_CPUID   = 32'h0800;
    localparam logic [31:0] PORT_FEAT    = 32'h0802;
    localparam logic [31:0] PORT_MODSTAT = 32'h0803;
    localparam logic [31:0] PORT_LAMP    = 32'h0808;
    localparam logic [31:0] PORT_EQUIP   = 32'h080C;
    localparam logic [31:0] PORT_LOCK1   = 32'h0810;
    localparam logic [31:0] PORT_LOCK2   = 32'h0812;
    localparam logic [31:0] PORT_INVAL   = 32'h0814;
    localparam logic [31:0] PORT_KEY     = 32'h0818;
    localparam logic [31:0] PORT_CTRL    = 32'h081C;
    localparam logic [31:0] PORT_CACHE   = 32'h0823;
    localparam logic [31:0] PORT_MAP     = 32'h0850;

    localparam logic [7:0] VAL_CPUID   = 8'hEF;
    localparam logic [7:0] VAL_FEAT    = 8'hAD;
    localparam logic [7:0] VAL_MODSTAT = 8'hE0;
    localparam logic [7:0] VAL_EQUIP   = 8'h3C;
    localparam logic [7:0] VAL_EXTFEAT = 8'h39;
    localparam logic [7:0] VAL_KEY     = 8'h00;
    localparam logic [7:0] VAL_CACHE   = 8'h03;
    localparam logic [7:0] VAL_FLOAT   = 8'hFF;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr_i,
    output sel_e              sel_o,
    output logic              rd_ok_o,
    output logic              wr_ok_o
);

    logic [31:0] a_ext;
    assign a_ext = 32'(addr_i);

    always_comb begin
        sel_o = SEL_NONE;
        unique case (a_ext)
            PORT_RSTEND:  sel_o = SEL_RSTEND;
            PORT_CPUID:   sel_o = SEL_CPUID;
            PORT_FEAT:    sel_o = SEL_FEAT;
            PORT_MODSTAT: sel_o = SEL_MODSTAT;
            PORT_LAMP:    sel_o = SEL_LAMP;
            PORT_EQUIP:   sel_o = SEL_EQUIP;
            PORT_LOCK1:   sel_o = SEL_LOCK1;
            PORT_LOCK2:   sel_o = SEL_LOCK2;
            PORT_INVAL:   sel_o = SEL_INVAL;
            PORT_KEY:     sel_o = SEL_KEY;
            PORT_CTRL:    sel_o = SEL_CTRL;
            PORT_CACHE:   sel_o = SEL_CACHE;
            PORT_MAP:     sel_o = SEL_MAP;
            default:      sel_o = SEL_NONE;
        endcase
    end

    always_comb begin
        unique case (sel_o)
            SEL_NONE, SEL_LAMP, SEL_LOCK2: rd_ok_o = 1'b0;
            default:                       rd_ok_o = 1'b1;
        endcase
        unique case (sel_o)
            SEL_NONE, SEL_EQUIP, SEL_KEY, SEL_CACHE: wr_ok_o = 1'b0;
            default:                                 wr_ok_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int CTRL_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_stb_i,
    input  sel_e              sel_i,
    input  logic [7:0]        wdata_i,
    output logic              soft_rst_o,
    output logic              endian_o,
    output logic              activity_o,
    output logic              lock1_o,
    output logic              lock2_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              map_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            soft_rst_o <= 1'b0;
            endian_o   <= 1'b0;
            activity_o <= 1'b0;
            lock1_o    <= 1'b0;
            lock2_o    <= 1'b0;
            ctrl_o     <= '0;
            map_o      <= 1'b0;
        end else begin
            lock1_o <= wr_stb_i && (sel_i == SEL_LOCK1);
            lock2_o <= wr_stb_i && (sel_i == SEL_LOCK2);
            if (wr_stb_i) begin
                unique case (sel_i)
                    SEL_RSTEND: begin
                        soft_rst_o <= wdata_i[0];
                        endian_o   <= wdata_i[1];
                    end
                    SEL_LAMP: activity_o <= wdata_i[0];
                    SEL_CTRL: ctrl_o     <= wdata_i[CTRL_W-1:0];
                    SEL_MAP:  map_o      <= wdata_i[0];
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
    import sysctl_pkg::*;
#(
    parameter int CTRL_W = 4
) (
    input  sel_e              sel_i,
    input  logic              endian_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              map_i,
    output logic [7:0]        rdata_o
);

    always_comb begin
        unique case (sel_i)
            SEL_RSTEND:  rdata_o = {6'b0, endian_i, 1'b0};
            SEL_CPUID:   rdata_o = VAL_CPUID;
            SEL_FEAT:    rdata_o = VAL_FEAT;
            SEL_MODSTAT: rdata_o = VAL_MODSTAT;
            SEL_EQUIP:   rdata_o = VAL_EQUIP;
            SEL_LOCK1:   rdata_o = VAL_EXTFEAT;
            SEL_KEY:     rdata_o = VAL_KEY;
            SEL_CTRL:    rdata_o = 8'(ctrl_i);
            SEL_CACHE:   rdata_o = VAL_CACHE;
            SEL_MAP:     rdata_o = {7'b0, map_i};
            default:     rdata_o = VAL_FLOAT;
        endcase
    end

endmodule

// File: rtl/sysctl_port_bank.sv
module sysctl_port_bank
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CTRL_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [7:0]        wr_data_i,
    input  logic              rd_en_i,
    output logic [7:0]        rd_data_o,
    output logic              err_o,
    output logic              soft_rst_o,
    output logic              endian_o,
    output logic              activity_o,
    output logic              lock1_o,
    output logic              lock2_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              map_o
);

    sel_e       sel;
    logic       rd_ok;
    logic       wr_ok;
    logic [7:0] rdata_mux;
    acc_e       acc_q;
    acc_e       acc_d;

    sysctl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i  (addr_i),
        .sel_o   (sel),
        .rd_ok_o (rd_ok),
        .wr_ok_o (wr_ok)
    );

    // Next tracker state: fault on collision or on a port that rejects the access.
    always_comb begin
        if (wr_en_i && rd_en_i)  acc_d = ACC_FAULT;
        else if (wr_en_i)        acc_d = wr_ok ? ACC_WRITE : ACC_FAULT;
        else if (rd_en_i)        acc_d = rd_ok ? ACC_READ : ACC_FAULT;
        else                     acc_d = ACC_IDLE;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) acc_q <= ACC_IDLE;
        else       acc_q <= acc_d;
    end

    sysctl_regs #(.CTRL_W(CTRL_W)) u_regs (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_stb_i   (acc_d == ACC_WRITE),
        .sel_i      (sel),
        .wdata_i    (wr_data_i),
        .soft_rst_o (soft_rst_o),
        .endian_o   (endian_o),
        .activity_o (activity_o),
        .lock1_o    (lock1_o),
        .lock2_o    (lock2_o),
        .ctrl_o     (ctrl_o),
        .map_o      (map_o)
    );

    sysctl_rdmux #(.CTRL_W(CTRL_W)) u_mux (
        .sel_i    (sel),
        .endian_i (endian_o),
        .ctrl_i   (ctrl_o),
        .map_i    (map_o),
        .rdata_o  (rdata_mux)
    );

    // Output process: read data captured on a lone read (0xFF on unmapped).
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rd_data_o <= 8'h00;
        end else begin
            unique case (acc_d)
                ACC_READ:  rd_data_o <= rdata_mux;
                ACC_FAULT: if (rd_en_i && !wr_en_i) rd_data_o <= VAL_FLOAT;
                default: ;
            endcase
        end
    end

    assign err_o = (acc_q == ACC_FAULT);

endmodule

// File: rtl/sysctl_port_bank_chk.sv
module sysctl_port_bank_chk #(
    parameter int ADDR_W = 16,
    parameter int CTRL_W = 4
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic [7:0]        wr_data_i,
    input logic              rd_en_i,
    input logic              err_o,
    input logic              soft_rst_o,
    input logic              endian_o,
    input logic              activity_o,
    input logic              lock1_o,
    input logic              lock2_o,
    input logic [CTRL_W-1:0] ctrl_o,
    input logic              map_o
);

    logic [31:0] a_ext;
    logic        wr_only;
    assign a_ext   = 32'(addr_i);
    assign wr_only = wr_en_i && !rd_en_i;

    a_r1_soft_reset: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_only && a_ext == 32'h0092) |=> (soft_rst_o == $past(wr_data_i[0])));

    a_r2_endian: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_only && a_ext == 32'h0092) |=> (endian_o == $past(wr_data_i[1])));

    a_r4_lock1_cause: assert property (@(posedge clk_i) disable iff (rst_i)
        lock1_o |-> $past(wr_only && a_ext == 32'h0810));

    a_r4_lock2_cause: assert property (@(posedge clk_i) disable iff (rst_i)
        lock2_o |-> $past(wr_only && a_ext == 32'h0812));

    a_r4_locks_apart: assert property (@(posedge clk_i) disable iff (rst_i)
        !(lock1_o && lock2_o));

    a_r6_map: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_only && a_ext == 32'h0850) |=> (map_o == $past(wr_data_i[0])));

    a_r10_fault_keeps_state: assert property (@(posedge clk_i) disable iff (rst_i)
        err_o |-> ($stable(ctrl_o) && $stable(endian_o) && $stable(map_o)
                   && $stable(activity_o) && $stable(soft_rst_o)
                   && !lock1_o && !lock2_o));

    a_r11_reset_state: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (!soft_rst_o && !endian_o && !activity_o && ctrl_o == '0
                          && !map_o && !err_o && !lock1_o && !lock2_o));

endmodule

bind sysctl_port_bank sysctl_port_bank_chk #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rd_en_i    (rd_en_i),
    .err_o      (err_o),
    .soft_rst_o (soft_rst_o),
    .endian_o   (endian_o),
    .activity_o (activity_o),
    .lock1_o    (lock1_o),
    .lock2_o    (lock2_o),
    .ctrl_o     (ctrl_o),
    .map_o      (map_o)
);

// File: tb/sysctl_port_bank_test.sv
module sysctl_port_bank_test;

    localparam int AW = 12;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_data;
    logic          err, soft_rst, endian, activity, lock1, lock2, map;
    logic [CW-1:0] ctrl;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sysctl_port_bank #(.ADDR_W(AW), .CTRL_W(CW)) uut (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
        .err_o(err), .soft_rst_o(soft_rst), .endian_o(endian),
        .activity_o(activity), .lock1_o(lock1), .lock2_o(lock2),
        .ctrl_o(ctrl), .map_o(map)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_rd(input int a, input int en, input int ct, input int mp);
        case (a)
            'h092: return en << 1;
            'h800: return 'hEF;
            'h802: return 'hAD;
            'h803: return 'hE0;
            'h80C: return 'h3C;
            'h810: return 'h39;
            'h818: return 'h00;
            'h81C: return ct & 'hF;
            'h823: return 'h03;
            'h850: return mp;
            default: return 'hFF;
        endcase
    endfunction

    function automatic bit rd_ok(input int a);
        return a == 'h092 || a == 'h800 || a == 'h802 || a == 'h803 || a == 'h80C ||
               a == 'h810 || a == 'h814 || a == 'h818 || a == 'h81C || a == 'h823 ||
               a == 'h850;
    endfunction

    function automatic bit wr_ok(input int a);
        return a == 'h092 || a == 'h800 || a == 'h802 || a == 'h803 || a == 'h808 ||
               a == 'h810 || a == 'h812 || a == 'h814 || a == 'h81C || a == 'h850;
    endfunction

    function automatic int state_word();
        return {soft_rst, endian, activity, map, 4'(ctrl)};
    endfunction

    // Each access: drive at a falling edge, sample at the next falling edge.
    task automatic do_wr(input int a, input int d);
        @(negedge clk);
        addr = AW'(a); wr_data = 8'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input int a);
        @(negedge clk);
        addr = AW'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk("R11 state", state_word(), 0);
        chk("R11 err/locks", {err, lock1, lock2}, 0);
        chk("R11 rdata", rd_data, 0);

        // R7 R9: read sweep with cleared state
        for (int a = 0; a < (1 << AW); a++) begin
            do_rd(a);
            chk("R9 read data", rd_data, exp_rd(a, 0, 0, 0));
            chk("R9 read err", err, !rd_ok(a));
        end

        // R2 R5 R6: load state then read sweep again
        do_wr('h092, 'h02);
        chk("R2 endian set", endian, 1);
        chk("R1 reset low", soft_rst, 0);
        do_wr('h81C, 'hFA);
        chk("R5 ctrl masked", ctrl, 'hA);
        do_wr('h850, 'hFF);
        chk("R6 map set", map, 1);
        for (int a = 0; a < (1 << AW); a++) begin
            do_rd(a);
            chk("R7 read data loaded", rd_data, exp_rd(a, 1, 'hA, 1));
        end

        // R7: read data holds through idle cycles and rejected writes
        do_rd('h800);
        repeat (3) @(negedge clk);
        chk("R7 hold idle", rd_data, 'hEF);
        do_wr('h80C, 'h55);
        chk("R7 hold after bad write", rd_data, 'hEF);

        // R5: every data byte to the control port
        for (int d = 0; d < 256; d++) begin
            do_wr('h81C, d);
            do_rd('h81C);
            chk("R5 ctrl read", rd_data, d & 'hF);
        end

        // clear, then zero write sweep: R4 R8 R10
        do_wr('h092, 0); do_wr('h81C, 0); do_wr('h850, 0);
        for (int a = 0; a < (1 << AW); a++) begin
            do_wr(a, 0);
            chk("R10 write err", err, !wr_ok(a));
            chk("R4 lock1 pulse", lock1, a == 'h810);
            chk("R4 lock2 pulse", lock2, a == 'h812);
            chk("R8 no change", state_word(), 0);
        end

        // R10: all-ones writes to rejected ports change nothing
        for (int a = 0; a < (1 << AW); a++) begin
            if (!wr_ok(a)) begin
                do_wr(a, 'hFF);
                chk("R10 err", err, 1);
                chk("R10 state kept", state_word(), 0);
                chk("R10 no strobe", {lock1, lock2}, 0);
            end
        end

        // R8: read-only and invalidate ports with all ones
        do_wr('h800, 'hFF); chk("R8 ro 800", {err, 8'(state_word())}, 0);
        do_wr('h814, 'hFF); chk("R8 inval 814", {err, 8'(state_word())}, 0);
        do_rd('h800);
        chk("R8 constant unchanged", rd_data, 'hEF);

        // R1 R2: reset and endian independent bits
        do_wr('h092, 'h01);
        chk("R1 soft reset high", soft_rst, 1);
        chk("R2 endian low", endian, 0);
        repeat (4) @(negedge clk);
        chk("R1 soft reset held", soft_rst, 1);
        do_rd('h092);
        chk("R2 read bit1 only", rd_data, 0);
        do_wr('h092, 'h03);
        do_rd('h092);
        chk("R2 read endian", rd_data, 'h02);
        do_wr('h092, 'h00);
        chk("R1 soft reset low", soft_rst, 0);

        // R3: lamp bit
        do_wr('h808, 'hFE);
        chk("R3 lamp off", activity, 0);
        do_wr('h808, 'h01);
        chk("R3 lamp on", activity, 1);
        do_rd('h808);
        chk("R9 lamp port not readable", {err, rd_data}, 'h1FF);

        // R4: strobe lasts one cycle, back-to-back writes give two pulses
        do_wr('h810, 'h5A);
        chk("R4 lock1 high", lock1, 1);
        @(negedge clk);
        chk("R4 lock1 one cycle", lock1, 0);
        @(negedge clk);
        addr = AW'('h812); wr_data = 8'h00; wr_en = 1'b1;
        @(negedge clk);
        chk("R4 lock2 first", lock2, 1);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R4 lock2 second", lock2, 1);
        @(negedge clk);
        chk("R4 lock2 done", lock2, 0);

        // R10: both strobes together
        do_rd('h823);
        @(negedge clk);
        addr = AW'('h81C); wr_data = 8'h07; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R10 collision err", err, 1);
        chk("R10 collision ctrl", ctrl, 0);
        chk("R10 collision rdata", rd_data, 'h03);
        @(negedge clk);
        chk("R10 err one cycle", err, 0);

        // R11: mid-run reset
        do_wr('h092, 'h03); do_wr('h81C, 'h0F); do_wr('h850, 1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 mid-run clear", state_word(), 0);
        chk("R11 mid-run rdata", rd_data, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule